// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is a single-master I2C engine that a processor runs one bus operation at a time. It has two 8-bit registers. The data register holds the byte to send, and after a receive it holds the byte that came back. A write to the control register carries a 4-bit command code in its low nibble. The command can be a START condition, a STOP condition, sending the data byte, reading a byte and acknowledging it, or reading the final byte and not acknowledging it. Software sequences the address and data bytes itself. It polls BUSY, or it waits for the interrupt pulse raised when BUSY drops, and then checks the acknowledge flags.

The bus lines are open-drain. The block drives each line low only through an output-enable signal and otherwise releases it to the pull-up. A pin-enable input chooses between the engine and two software-controlled enables, so the pins can also be bit-banged. The bit period comes from a divider of the system clock, with a default of about 78 kHz. The divider splits every bit into four equal quarters. The SCL input is never sampled, because clock stretching and arbitration are not supported. Between operations SCL is left released (high).

Top module: `i2c_cmd_master`

## Requirements
- R1: Command code 9 produces a START condition. SCL goes low, then SDA is released, then SCL is released, then SDA is pulled low. The operation ends with SCL high and SDA low.
- R2: Command code 5 produces a STOP condition. SCL goes low, then SDA is pulled low, then SCL is released, then SDA is released. The operation ends with both lines high.
- R3: Command code 3 sends the data register most significant bit first. It then releases SDA for a ninth clock. SDA changes only while SCL is low. Status bit 5 (RX_ACK) reads 1 when SDA was low at the ninth clock, and 0 otherwise.
- R4: Command code 2 clocks in eight bits, most significant bit first, into the data register and drives SDA low on the ninth clock. On completion status bit 4 (TX_ACK) reads 1.
- R5: Command code 6 clocks in eight bits into the data register and leaves SDA released on the ninth clock. Status bit 4 (TX_ACK) reads 0 afterwards.
- R6: Any command code other than 0, 2, 3, 5, 6 or 9 written while idle starts nothing and sets status bit 7 (ERROR). Any legal command written while idle clears ERROR.
- R7: A control write while status bit 6 (BUSY) is 1 is ignored and sets ERROR. Data register writes while BUSY is 1 are also ignored.
- R8: BUSY rises on the clock edge that accepts a command. It stays high for 4·Q clock cycles for START and STOP, and for 36·Q cycles for a byte, where Q is the quarter-bit length in clock cycles. The interrupt output is high for exactly the one cycle after BUSY falls.
- R9: SCL is released (scl_oe_o = 0) whenever the block is idle.
- R10: With the pin enable at 0, both output enables follow the two software enable inputs. With it at 1, they follow the engine.
- R11: Command code 0 starts no bus activity, leaves both lines unchanged and clears ERROR.
- R12: After reset the status register reads 0, the data register reads 0, the interrupt is low and both lines are released. The status layout is bit 7 ERROR, bit 6 BUSY, bit 5 RX_ACK, bit 4 TX_ACK, and bits 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wdata_i | input | 8 | Write data for either register |
| data_we_i | input | 1 | Write strobe for the data register |
| ctrl_we_i | input | 1 | Write strobe for the control register (command in bits 3:0) |
| data_o | output | 8 | Data register contents |
| status_o | output | 8 | Status: ERROR, BUSY, RX_ACK, TX_ACK, then four zero bits |
| irq_o | output | 1 | One-cycle pulse after BUSY falls |
| pin_en_i | input | 1 | 1 connects the engine to the pins, 0 hands them to software |
| sw_scl_oe_i | input | 1 | Software SCL pull-down enable |
| sw_sda_oe_i | input | 1 | Software SDA pull-down enable |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe_o | output | 1 | SCL pull-down enable (1 drives low) |
| sda_oe_o | output | 1 | SDA pull-down enable (1 drives low) |

## Verification
Two cases are the hardest to reach from the ports. The first is a command that lands on an engine already in the middle of an operation. The second is the acknowledge slot, where the slave, not the master, has to own SDA. The bench places a control write a few cycles into a START and checks that the waveform and the BUSY length are unchanged. A behavioural slave on the bench's wired-AND bus counts SCL falling edges. It pulls SDA low for an acknowledge or presents a chosen byte, so both polarities of RX_ACK and both receive commands are exercised against a cycle-level reference model.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   localparam logic [3:0] CMD_NOP     = 4'd0;
   localparam logic [3:0] CMD_RD_ACK  = 4'd2;
   localparam logic [3:0] CMD_WR      = 4'd3;
   localparam logic [3:0] CMD_STOP    = 4'd5;
   localparam logic [3:0] CMD_RD_NACK = 4'd6;
   localparam logic [3:0] CMD_START   = 4'd9;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_START,
      OP_STOP,
      OP_WR,
      OP_RD_ACK,
      OP_RD_NACK
   } op_e;

   typedef struct packed {
      logic legal;
      logic bus;
      op_e  op;
   } cmd_dec_t;

   function automatic cmd_dec_t decode_cmd(input logic [3:0] code);
      cmd_dec_t d;
      d.legal = 1'b1;
      d.bus   = 1'b1;
      d.op    = OP_IDLE;
      case (code)
         CMD_NOP:     d.bus = 1'b0;
         CMD_RD_ACK:  d.op  = OP_RD_ACK;
         CMD_WR:      d.op  = OP_WR;
         CMD_STOP:    d.op  = OP_STOP;
         CMD_RD_NACK: d.op  = OP_RD_NACK;
         CMD_START:   d.op  = OP_START;
         default: begin
            d.legal = 1'b0;
            d.bus   = 1'b0;
         end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
   parameter int QDIV = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> (cnt_q <= LAST));

endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES:0] chain;

   assign chain[0] = d_i;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i+1] <= 1'b1;
         else        chain[i+1] <= chain[i];
      end
   end

   assign q_o = chain[STAGES];

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_cmd_pkg::*;
#(
   parameter int QDIV = 400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  op_e        op_i,
   input  logic [7:0] tx_i,
   input  logic       sda_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       rx_load_o,
   output logic       scl_o,
   output logic       sda_o,
   output logic [7:0] rx_o,
   output logic       rx_ack_o,
   output logic       tx_ack_o
);
   localparam int BYTE_BITS = 8;
   localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

   op_e        op_q;
   logic       busy_q;
   logic [1:0] qtr_q;
   logic [3:0] bit_q;
   logic [7:0] sh_q;
   logic [7:0] rx_q;
   logic       rxack_q;
   logic       txack_q;
   logic       scl_q;
   logic       sda_q;
   logic       tick;
   logic       accept;
   logic       is_xfer;
   logic       is_rd;
   logic       last_bit;
   logic       bit_val;

   assign accept   = start_i && !busy_q;
   assign is_rd    = (op_q == OP_RD_ACK) || (op_q == OP_RD_NACK);
   assign is_xfer  = is_rd || (op_q == OP_WR);
   assign last_bit = (bit_q == (is_xfer ? ACK_SLOT : 4'd0));

   always_comb begin
      if (bit_q < ACK_SLOT) begin
         bit_val = (op_q == OP_WR) ? sh_q[~bit_q[2:0]] : 1'b1;
      end else begin
         bit_val = (op_q != OP_RD_ACK);
      end
   end

   i2c_qtr_timer #(.QDIV(QDIV)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .run_i   (busy_q),
      .tick_o  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         busy_q  <= 1'b0;
         qtr_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         rx_q    <= '0;
         rxack_q <= 1'b0;
         txack_q <= 1'b0;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
      end else if (accept) begin
         busy_q  <= 1'b1;
         op_q    <= op_i;
         qtr_q   <= '0;
         bit_q   <= '0;
         sh_q    <= tx_i;
         rxack_q <= 1'b0;
         txack_q <= 1'b0;
         scl_q   <= 1'b0;
      end else if (tick) begin
         qtr_q <= qtr_q + 2'd1;
         case (qtr_q)
            2'd0: begin
               if (op_q == OP_START)     sda_q <= 1'b1;
               else if (op_q == OP_STOP) sda_q <= 1'b0;
               else                      sda_q <= bit_val;
            end
            2'd1: scl_q <= 1'b1;
            2'd2: begin
               if (op_q == OP_START)     sda_q <= 1'b0;
               else if (op_q == OP_STOP) sda_q <= 1'b1;
               if (op_q == OP_WR && bit_q == ACK_SLOT) rxack_q <= ~sda_i;
               if (is_rd && bit_q < ACK_SLOT)          rx_q <= {rx_q[6:0], sda_i};
            end
            default: begin
               if (last_bit) begin
                  busy_q <= 1'b0;
                  op_q   <= OP_IDLE;
                  if (op_q == OP_RD_ACK) txack_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 4'd1;
                  scl_q <= 1'b0;
               end
            end
         endcase
      end
   end

   assign done_o    = tick && (qtr_q == 2'd3) && last_bit;
   assign rx_load_o = done_o && is_rd;
   assign busy_o    = busy_q;
   assign scl_o     = scl_q;
   assign sda_o     = sda_q;
   assign rx_o      = rx_q;
   assign rx_ack_o  = rxack_q;
   assign tx_ack_o  = txack_q;

   p_sda_quiet_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && is_xfer && scl_q && $past(scl_q)) |-> $stable(sda_q));

   p_idle_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> scl_q);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_q);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2c_cmd_pkg::*;
#(
   parameter int CLK_HZ      = 125_000_000,
   parameter int BIT_HZ      = 78_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] wdata_i,
   input  logic       data_we_i,
   input  logic       ctrl_we_i,
   output logic [7:0] data_o,
   output logic [7:0] status_o,
   output logic       irq_o,
   input  logic       pin_en_i,
   input  logic       sw_scl_oe_i,
   input  logic       sw_sda_oe_i,
   input  logic       sda_i,
   output logic       scl_oe_o,
   output logic       sda_oe_o
);
   localparam int QDIV = CLK_HZ / (4 * BIT_HZ);

   if (QDIV < SYNC_STAGES + 2) begin : g_bad_qdiv
      $error("quarter-bit divider too short for the SDA synchronizer");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   cmd_dec_t   dec;
   logic       busy;
   logic       done;
   logic       rx_load;
   logic       scl_lvl;
   logic       sda_lvl;
   logic       sda_sync;
   logic [7:0] rx_byte;
   logic       rx_ack;
   logic       tx_ack;
   logic [7:0] data_q;
   logic       err_q;
   logic       irq_q;

   assign dec = decode_cmd(wdata_i[3:0]);

   i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sda_i),
      .q_o   (sda_sync)
   );

   i2c_byte_engine #(.QDIV(QDIV)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (ctrl_we_i && dec.legal && dec.bus),
      .op_i      (dec.op),
      .tx_i      (data_q),
      .sda_i     (sda_sync),
      .busy_o    (busy),
      .done_o    (done),
      .rx_load_o (rx_load),
      .scl_o     (scl_lvl),
      .sda_o     (sda_lvl),
      .rx_o      (rx_byte),
      .rx_ack_o  (rx_ack),
      .tx_ack_o  (tx_ack)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= done;
         if (ctrl_we_i) err_q <= busy ? 1'b1 : !dec.legal;
         if (rx_load)                 data_q <= rx_byte;
         else if (data_we_i && !busy) data_q <= wdata_i;
      end
   end

   assign data_o   = data_q;
   assign status_o = {err_q, busy, rx_ack, tx_ack, 4'b0000};
   assign irq_o    = irq_q;
   assign scl_oe_o = pin_en_i ? ~scl_lvl : sw_scl_oe_i;
   assign sda_oe_o = pin_en_i ? ~sda_lvl : sw_sda_oe_i;

   p_irq_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (!busy && $past(busy)));

   p_busy_write_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we_i && busy) |=> err_q);

   p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we_i && !busy && !dec.legal) |=> (err_q && !busy));

   p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we_i && !busy && wdata_i[3:0] == CMD_NOP) |=> (!err_q && !busy && $stable(sda_lvl)));

endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
   localparam int QD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wdata = '0;
   logic       data_we = 1'b0;
   logic       ctrl_we = 1'b0;
   logic       pin_en = 1'b1;
   logic       sw_scl = 1'b0;
   logic       sw_sda = 1'b0;
   logic       slv_pull = 1'b0;
   logic [7:0] data_o;
   logic [7:0] status;
   logic       irq;
   logic       scl_oe;
   logic       sda_oe;
   wire        scl_bus = ~scl_oe;
   wire        sda_bus = ~(sda_oe | slv_pull);

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   i2c_cmd_master #(.CLK_HZ(16), .BIT_HZ(1), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .data_we_i(data_we),
      .ctrl_we_i(ctrl_we), .data_o(data_o), .status_o(status), .irq_o(irq),
      .pin_en_i(pin_en), .sw_scl_oe_i(sw_scl), .sw_sda_oe_i(sw_sda),
      .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural slave: counts SCL falls, captures SDA at SCL rises
   int         slv_mode = 0;
   logic [7:0] slv_byte = '0;
   int         nfall = 0;
   logic [7:0] cap = '0;
   logic       cap9 = 1'b1;
   logic       scl_prev = 1'b1;
   always @(negedge clk) begin
      if (scl_prev && !scl_bus) begin
         nfall = nfall + 1;
         if (slv_mode == 1)      slv_pull <= (nfall == 9);
         else if (slv_mode == 2) slv_pull <= (nfall >= 1 && nfall <= 8) ? !slv_byte[8-nfall] : 1'b0;
         else                    slv_pull <= 1'b0;
      end
      if (!scl_prev && scl_bus) begin
         if (nfall >= 1 && nfall <= 8) cap = {cap[6:0], sda_bus};
         if (nfall == 9) cap9 = sda_bus;
      end
      scl_prev = scl_bus;
   end

   // cycle-level reference model
   int         cyc = 0, t0 = 0, m_op = 0;
   bit         m_busy, m_scl, m_sda, m_err, m_rxack, m_txack, m_irq;
   logic [7:0] m_data, m_tx, m_rx;
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_scl = 1; m_sda = 1; m_err = 0; m_rxack = 0; m_txack = 0;
         m_irq = 0; m_data = 0; m_tx = 0; m_rx = 0;
      end else begin
         automatic bit pb = m_busy;
         automatic bit xf = (m_op == 2 || m_op == 3 || m_op == 6);
         m_irq = 0;
         if (pb) begin
            automatic int el = cyc - t0;
            if (el % QD == 0) begin
               automatic int k = el / QD;
               automatic int b = k / 4;
               automatic int qq = k % 4;
               if (k == (xf ? 36 : 4)) begin
                  m_busy = 0; m_irq = 1;
                  if (m_op == 2) m_txack = 1;
                  if (m_op == 2 || m_op == 6) m_data = m_rx;
               end else begin
                  if (qq == 0) m_scl = 0;
                  if (qq == 2) m_scl = 1;
                  if (qq == 1) begin
                     if (m_op == 9) m_sda = 1;
                     else if (m_op == 5) m_sda = 0;
                     else if (b < 8) m_sda = (m_op == 3) ? m_tx[7-b] : 1'b1;
                     else m_sda = (m_op != 2);
                  end
                  if (qq == 3) begin
                     if (m_op == 9) m_sda = 0;
                     if (m_op == 5) m_sda = 1;
                     if (m_op == 3 && b == 8) m_rxack = !sda_bus;
                     if ((m_op == 2 || m_op == 6) && b < 8) m_rx = {m_rx[6:0], sda_bus};
                  end
               end
            end
         end
         if (ctrl_we && pb) m_err = 1;
         else if (ctrl_we) begin
            automatic int c = wdata[3:0];
            automatic bit legal = (c == 0 || c == 2 || c == 3 || c == 5 || c == 6 || c == 9);
            m_err = !legal;
            if (legal && c != 0) begin
               m_busy = 1; t0 = cyc; m_op = c; m_rxack = 0; m_txack = 0; m_scl = 0; m_tx = m_data;
            end
         end
         if (data_we && !pb) m_data = wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(status[7] == m_err, "R6 error", status[7], m_err);
         chk(status[6] == m_busy, "R8 busy", status[6], m_busy);
         chk(status[5] == m_rxack, "R3 rx_ack", status[5], m_rxack);
         chk(status[4] == m_txack, "R4 tx_ack", status[4], m_txack);
         chk(status[3:0] == 4'h0, "R12 low bits", status[3:0], 0);
         chk(irq == m_irq, "R8 irq", irq, m_irq);
         chk(data_o == m_data, "R4 data", data_o, m_data);
         chk(scl_oe == (pin_en ? !m_scl : sw_scl), "R9 scl_oe", scl_oe, pin_en ? !m_scl : sw_scl);
         chk(sda_oe == (pin_en ? !m_sda : sw_sda), "R3 sda_oe", sda_oe, pin_en ? !m_sda : sw_sda);
      end
   end

   task automatic issue(input logic [3:0] code);
      @(negedge clk);
      nfall = 0;
      wdata = {4'h0, code};
      ctrl_we = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic put_data(input logic [7:0] v);
      @(negedge clk);
      wdata = v; data_we = 1'b1;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (status[6]) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(status == 8'h00, "R12 status", status, 0);
      chk(data_o == 8'h00, "R12 data", data_o, 0);
      chk(!irq && !scl_oe && !sda_oe, "R12 lines", {irq, scl_oe, sda_oe}, 0);

      // R1 START and its length (R8)
      issue(4'd9);
      wait_idle(n);
      chk(n == 4 * QD, "R8 start length", n, 4 * QD);
      chk(scl_bus && !sda_bus, "R1 start end", {scl_bus, sda_bus}, 2'b10);

      // R3 transmit with ACK, R8 byte length, R9 idle SCL
      slv_mode = 1;
      put_data(8'hC3);
      issue(4'd3);
      wait_idle(n);
      chk(n == 36 * QD, "R8 byte length", n, 36 * QD);
      chk(cap == 8'hC3, "R3 bits on bus", cap, 8'hC3);
      chk(status[5] == 1'b1, "R3 ack seen", status[5], 1);
      chk(scl_bus == 1'b1, "R9 scl idle", scl_bus, 1);

      // R3 transmit without ACK
      slv_mode = 0;
      put_data(8'h5A);
      issue(4'd3);
      wait_idle(n);
      chk(cap == 8'h5A, "R3 bits on bus", cap, 8'h5A);
      chk(status[5] == 1'b0, "R3 nack seen", status[5], 0);

      // R4 receive with ACK
      slv_mode = 2; slv_byte = 8'hA5;
      issue(4'd2);
      wait_idle(n);
      chk(data_o == 8'hA5, "R4 rx byte", data_o, 8'hA5);
      chk(cap9 == 1'b0, "R4 ack driven", cap9, 0);
      chk(status[4] == 1'b1, "R4 tx_ack", status[4], 1);

      // R5 receive last byte with NACK
      slv_byte = 8'h3C;
      issue(4'd6);
      wait_idle(n);
      chk(data_o == 8'h3C, "R5 rx byte", data_o, 8'h3C);
      chk(cap9 == 1'b1, "R5 nack", cap9, 1);
      chk(status[4] == 1'b0, "R5 tx_ack", status[4], 0);

      // R2 STOP
      slv_mode = 0;
      issue(4'd5);
      wait_idle(n);
      chk(scl_bus && sda_bus, "R2 stop end", {scl_bus, sda_bus}, 2'b11);

      // R6 illegal code, R11 no-op
      issue(4'd7);
      chk(status[7] && !status[6], "R6 illegal", status[7:6], 2'b10);
      issue(4'd0);
      chk(!status[7] && !status[6], "R11 nop", status[7:6], 2'b00);
      chk(!scl_oe && !sda_oe, "R11 lines unchanged", {scl_oe, sda_oe}, 0);
      issue(4'd13);
      chk(status[7] == 1'b1, "R6 illegal 13", status[7], 1);

      // R7 writes while busy are ignored
      issue(4'd9);
      chk(status[7] == 1'b0, "R6 legal clears error", status[7], 0);
      repeat (2) @(negedge clk);
      wdata = 8'h03; ctrl_we = 1'b1; data_we = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0; data_we = 1'b0;
      chk(status[7] == 1'b1, "R7 busy write error", status[7], 1);
      wait_idle(n);
      chk(n == 4 * QD - 3, "R7 start unchanged", n, 4 * QD - 3);
      chk(scl_bus && !sda_bus, "R7 still start", {scl_bus, sda_bus}, 2'b10);
      chk(data_o == 8'h3C, "R7 data kept", data_o, 8'h3C);

      // R10 pin enable
      pin_en = 1'b0; sw_scl = 1'b1; sw_sda = 1'b0;
      @(negedge clk);
      chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R10 sw 10", {scl_oe, sda_oe}, 2'b10);
      sw_scl = 1'b0; sw_sda = 1'b1;
      @(negedge clk);
      chk(scl_oe == 1'b0 && sda_oe == 1'b1, "R10 sw 01", {scl_oe, sda_oe}, 2'b01);
      sw_sda = 1'b0; pin_en = 1'b1;
      @(negedge clk);
      chk(sda_oe == 1'b1, "R10 engine again", sda_oe, 1);

      issue(4'd5);
      wait_idle(n);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule